// File: doc/BRIEF.md
# Dual-Mode UART with Address Filtering

This block is a full-duplex asynchronous serial port driven by a single 8-bit control/status byte and a data byte. Its frame format is selected by software: eight data bits, or nine data bits where the extra bit sent comes from a control bit. In nine-bit mode the receiver can drop every frame whose ninth bit is 0. On a multi-drop line, a node then wakes only on address frames. In eight-bit mode the same control bit makes the receiver refuse frames with a bad stop level.

Bit timing comes from an external enable pulse at sixteen times the bit rate. Frames are sent LSB first, with one start bit (0) and one stop bit (1), and the line idles high. The receiver brings the line through a two-stage synchronizer. It confirms the start bit at mid-bit and samples each later bit at its centre. Two sticky flags, transmit-done and receive-done, drive a single interrupt request.

Top module: `dual_mode_uart`

## Requirements
- R1: After reset the control byte (reg_sel_i=0) reads 0x00, txd_o is 1 and irq_o is 0. Control bits: bit0 nine-bit format, bit1 filter enable, bit2 receive enable, bit3 transmit ninth bit, bit4 received ninth/stop bit, bit5 transmit-done flag, bit6 receive-done flag, bit7 reads 0.
- R2: A data write (reg_sel_i=1) while idle sends a frame. The frame is a start bit of 0, then eight data bits LSB first, then a stop bit of 1. Each bit lasts 16 baud ticks.
- R3: With bit0 set, the transmitter sends bit3 as a ninth bit between the last data bit and the stop bit.
- R4: The transmit-done flag is still 0 during the last data bit: the eighth bit in eight-bit mode, the ninth bit in nine-bit mode. It becomes 1 during the stop bit in both modes.
- R5: A data write while a frame is being sent is ignored. The frame in progress keeps its original bits.
- R6: With bit2 clear, incoming frames change neither the receive-done flag nor the receive data byte.
- R7: In eight-bit mode with bit1 clear, a received frame stores its byte in the data register (read with reg_sel_i=1), copies its stop level into bit4 and sets the receive-done flag.
- R8: In eight-bit mode with bit1 set, a frame whose stop level is 0 sets no flag and changes neither the data byte nor bit4.
- R9: In nine-bit mode, bit4 takes the received ninth bit. With bit1 set, only frames whose ninth bit is 1 set the flag and update the data byte and bit4. With bit1 clear, every frame does.
- R10: Both flags stay 1 until software writes 0 to them. irq_o is 1 exactly while either flag is 1.
- R11: A low pulse on the line shorter than half a bit is rejected and produces no frame.
- R12: If a hardware flag set and a software write of the control byte fall in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control byte, 1 data byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| baud_tick_i | input | 1 | Enable pulse at 16x the bit rate |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A received frame raises its flag in the same cycle in which software may be writing the control byte to clear the flags. Only a precedence rule decides the outcome. The bench starts a frame and, in a parallel thread, writes the control byte at cycle offsets swept across the flag-set instant. Writes that land on or before that instant must leave the flag at 1, and later writes must leave it at 0. The offsets are counted from the bench's own drive of the start edge, through the synchronizer and the mid-bit sampling points.

// File: rtl/dmu_pkg.sv
package dmu_pkg;
  localparam int unsigned CTRL_W = 7;
  localparam int unsigned CB_FMT9 = 0;
  localparam int unsigned CB_CHK  = 1;
  localparam int unsigned CB_RXEN = 2;
  localparam int unsigned CB_TX9  = 3;
  localparam int unsigned CB_RX9  = 4;
  localparam int unsigned CB_TXF  = 5;
  localparam int unsigned CB_RXF  = 6;

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_NINTH, TX_STOP} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // filter: 9-bit uses the ninth bit, 8-bit uses the stop level
  function automatic logic rx_accept(logic fmt9, logic chk, logic bit9, logic stop);
    return !chk || (fmt9 ? bit9 : stop);
  endfunction
endpackage

// File: rtl/dmu_tx.sv
module dmu_tx
  import dmu_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  logic          fmt9_i,
  input  logic          bit9_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          txd_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned IW = $clog2(DW);

  tx_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [DW:0]   sh_q;
  logic          nine_q, txd_q, done_q;
  logic          bit_end;

  assign bit_end = tick_i && (cnt_q == CW'(OSR-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      nine_q <= 1'b0;
      txd_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q != TX_IDLE && tick_i) cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      case (st_q)
        TX_IDLE: begin
          txd_q <= 1'b1;
          if (start_i) begin
            sh_q   <= {bit9_i, data_i};
            nine_q <= fmt9_i;
            cnt_q  <= '0;
            txd_q  <= 1'b0;
            st_q   <= TX_START;
          end
        end
        TX_START: if (bit_end) begin
          txd_q <= sh_q[0];
          sh_q  <= sh_q >> 1;
          idx_q <= '0;
          st_q  <= TX_DATA;
        end
        TX_DATA: if (bit_end) begin
          if (idx_q == IW'(DW-1)) begin
            if (nine_q) begin
              txd_q <= sh_q[0];
              st_q  <= TX_NINTH;
            end else begin
              txd_q  <= 1'b1;
              done_q <= 1'b1;
              st_q   <= TX_STOP;
            end
          end else begin
            txd_q <= sh_q[0];
            sh_q  <= sh_q >> 1;
            idx_q <= idx_q + 1'b1;
          end
        end
        TX_NINTH: if (bit_end) begin
          txd_q  <= 1'b1;
          done_q <= 1'b1;
          st_q   <= TX_STOP;
        end
        TX_STOP: if (bit_end) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != TX_IDLE);
  assign done_o = done_q;
  assign txd_o  = txd_q;
endmodule

// File: rtl/dmu_rx.sv
module dmu_rx
  import dmu_pkg::*;
#(
  parameter int unsigned OSR  = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          fmt9_i,
  input  logic          rxd_i,
  output logic          evt_o,
  output logic [DW-1:0] data_o,
  output logic          bit9_o,
  output logic          stop_o,
  output logic          fmt9_o,
  output logic          busy_o
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned RIW = $clog2(DW+1);

  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  rx_state_e       st_q;
  logic [CW-1:0]   cnt_q;
  logic [RIW-1:0]  idx_q;
  logic [DW:0]     sh_q;
  logic            nine_q, evt_q, bit9_q, stop_q, fmt9_q;
  logic [DW-1:0]   data_q;
  logic            bit_end, mid_start;
  logic [RIW-1:0]  last_idx;

  assign rx_s      = sync_q[SYNC-1];
  assign bit_end   = tick_i && (cnt_q == CW'(OSR-1));
  assign mid_start = tick_i && (cnt_q == CW'(OSR/2-1));
  assign last_idx  = nine_q ? RIW'(DW) : RIW'(DW-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC-2:0], rxd_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      nine_q <= 1'b0;
      evt_q  <= 1'b0;
      data_q <= '0;
      bit9_q <= 1'b0;
      stop_q <= 1'b0;
      fmt9_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (!en_i) begin
        st_q  <= RX_IDLE;
        cnt_q <= '0;
      end else begin
        case (st_q)
          RX_IDLE: if (tick_i && !rx_s) begin
            st_q   <= RX_START;
            cnt_q  <= '0;
            nine_q <= fmt9_i;
          end
          RX_START: if (tick_i) begin
            if (mid_start) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= rx_s ? RX_IDLE : RX_DATA;  // glitch if high again
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: if (tick_i) begin
            if (bit_end) begin
              cnt_q <= '0;
              sh_q  <= {rx_s, sh_q[DW:1]};
              if (idx_q == last_idx) st_q <= RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: if (tick_i) begin
            if (bit_end) begin
              cnt_q  <= '0;
              evt_q  <= 1'b1;
              stop_q <= rx_s;
              data_q <= nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
              bit9_q <= nine_q & sh_q[DW];
              fmt9_q <= nine_q;
              st_q   <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign evt_o  = evt_q;
  assign data_o = data_q;
  assign bit9_o = bit9_q;
  assign stop_o = stop_q;
  assign fmt9_o = fmt9_q;
  assign busy_o = (st_q != RX_IDLE);
endmodule

// File: rtl/dmu_regs.sv
module dmu_regs
  import dmu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              data_wr_i,
  input  logic              sel_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              tx_busy_i,
  input  logic              tx_done_i,
  input  logic              rx_evt_i,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              rx_bit9_i,
  input  logic              rx_stop_i,
  input  logic              rx_fmt9_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     rdata_o,
  output logic              tx_start_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     rxbuf_q;
  logic              take;

  assign take = rx_evt_i && rx_accept(rx_fmt9_i, ctrl_q[CB_CHK], rx_bit9_i, rx_stop_i);

  // later assignments win: hardware set overrides a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rxbuf_q <= '0;
    end else begin
      if (ctrl_wr_i) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (tx_done_i) ctrl_q[CB_TXF] <= 1'b1;
      if (take) begin
        ctrl_q[CB_RXF] <= 1'b1;
        ctrl_q[CB_RX9] <= rx_fmt9_i ? rx_bit9_i : rx_stop_i;
        rxbuf_q        <= rx_data_i;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rdata_o    = sel_i ? rxbuf_q : {{(DW-CTRL_W){1'b0}}, ctrl_q};
  assign tx_start_o = data_wr_i && !tx_busy_i;
  assign irq_o      = ctrl_q[CB_TXF] | ctrl_q[CB_RXF];
endmodule

// File: rtl/dual_mode_uart.sv
module dual_mode_uart
  import dmu_pkg::*;
#(
  parameter int unsigned OSR  = 16,
  parameter int unsigned DW   = 8,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic          reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          baud_tick_i,
  input  logic          rxd_i,
  output logic          txd_o,
  output logic          irq_o
);
  logic [CTRL_W-1:0] ctrl;
  logic              ctrl_wr, data_wr;
  logic              tx_start, tx_busy, tx_done;
  logic              rx_evt, rx_bit9, rx_stop, rx_fmt9, rx_busy;
  logic [DW-1:0]     rx_data;

  assign ctrl_wr = reg_wr_i && !reg_sel_i;
  assign data_wr = reg_wr_i &&  reg_sel_i;

  dmu_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .ctrl_wr_i (ctrl_wr),
    .data_wr_i (data_wr),
    .sel_i     (reg_sel_i),
    .wdata_i   (reg_wdata_i),
    .tx_busy_i (tx_busy),
    .tx_done_i (tx_done),
    .rx_evt_i  (rx_evt),
    .rx_data_i (rx_data),
    .rx_bit9_i (rx_bit9),
    .rx_stop_i (rx_stop),
    .rx_fmt9_i (rx_fmt9),
    .ctrl_o    (ctrl),
    .rdata_o   (reg_rdata_o),
    .tx_start_o(tx_start),
    .irq_o     (irq_o)
  );

  dmu_tx #(.OSR(OSR), .DW(DW)) u_tx (
    .clk_i, .rst_ni,
    .tick_i (baud_tick_i),
    .start_i(tx_start),
    .data_i (reg_wdata_i),
    .fmt9_i (ctrl[CB_FMT9]),
    .bit9_i (ctrl[CB_TX9]),
    .busy_o (tx_busy),
    .done_o (tx_done),
    .txd_o  (txd_o)
  );

  dmu_rx #(.OSR(OSR), .DW(DW), .SYNC(SYNC)) u_rx (
    .clk_i, .rst_ni,
    .tick_i(baud_tick_i),
    .en_i  (ctrl[CB_RXEN]),
    .fmt9_i(ctrl[CB_FMT9]),
    .rxd_i (rxd_i),
    .evt_o (rx_evt),
    .data_o(rx_data),
    .bit9_o(rx_bit9),
    .stop_o(rx_stop),
    .fmt9_o(rx_fmt9),
    .busy_o(rx_busy)
  );
endmodule

// File: rtl/dmu_chk.sv
module dmu_chk
  import dmu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              txd_i,
  input logic              irq_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              ctrl_wr_i,
  input logic              tx_busy_i,
  input logic              tx_done_i,
  input logic              rx_busy_i,
  input logic              rx_evt_i,
  input logic              rx_fmt9_i
);
  // R2: line idles high whenever no frame is being sent
  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_i |-> txd_i);

  // R4: transmit-done pulse only occurs inside a frame
  a_r4_done_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |-> tx_busy_i);

  // R6: receiver parks when disabled
  a_r6_rx_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[CB_RXEN] |=> !rx_busy_i);

  a_r10_rxf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[CB_RXF] && !ctrl_wr_i |=> ctrl_i[CB_RXF]);

  a_r10_txf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i[CB_TXF] && !ctrl_wr_i |=> ctrl_i[CB_TXF]);

  a_r10_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(tx_done_i || rx_evt_i || ctrl_wr_i));

  a_r12_txf_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> ctrl_i[CB_TXF]);

  a_r12_rxf_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i && rx_fmt9_i && !ctrl_i[CB_CHK] |=> ctrl_i[CB_RXF]);
endmodule

bind dual_mode_uart dmu_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .txd_i     (txd_o),
  .irq_i     (irq_o),
  .ctrl_i    (ctrl),
  .ctrl_wr_i (ctrl_wr),
  .tx_busy_i (tx_busy),
  .tx_done_i (tx_done),
  .rx_busy_i (rx_busy),
  .rx_evt_i  (rx_evt),
  .rx_fmt9_i (rx_fmt9)
);

// File: tb/tb_dual_mode_uart.sv
`timescale 1ns/1ps
module tb_dual_mode_uart;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic       txd, irq;
  int         total = 0, bad = 0;
  bit         finished = 1'b0;
  logic [7:0] last_rx = 8'h00;

  always #2 clk = ~clk;

  dual_mode_uart dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .baud_tick_i(tick),
    .rxd_i(rxd), .txd_o(txd), .irq_o(irq)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic sel, logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic reg_read(logic sel, output logic [7:0] v);
    @(negedge clk);
    reg_sel = sel;
    #1 v = reg_rdata;
    reg_sel = 1'b0;
  endtask

  // caller is at a negedge; each bit is held 16 cycles (tick every cycle)
  task automatic send_rx(logic [8:0] bits, int nb, logic stop);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    for (int j = 0; j < nb; j++) begin
      rxd = bits[j];
      repeat (16) @(negedge clk);
    end
    rxd = stop;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic send_tx(logic [7:0] d, logic fmt9, logic b9, logic poke);
    int nb;
    nb = fmt9 ? 9 : 8;
    reg_write(1'b0, {4'b0, b9, 2'b00, fmt9});
    @(negedge clk);
    reg_sel = 1'b1; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
    repeat (7) @(negedge clk);
    check("R2 start bit", int'(txd), 0);
    for (int j = 0; j < nb; j++) begin
      if (poke && j == 0) begin
        reg_sel = 1'b1; reg_wdata = ~d; reg_wr = 1'b1;   // R5 write while busy
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
        repeat (15) @(negedge clk);
      end else repeat (16) @(negedge clk);
      if (j < 8) check(poke ? "R5 bit kept" : "R2 data bit", int'(txd), int'(d[j]));
      else       check("R3 ninth bit", int'(txd), int'(b9));
      if (j == nb - 1) check("R4 flag low in last bit", int'(reg_rdata[5]), 0);
    end
    repeat (16) @(negedge clk);
    check("R2 stop bit", int'(txd), 1);
    check("R4 flag in stop", int'(reg_rdata[5]), 1);
    check("R10 irq from tx", int'(irq), 1);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic       exp_f, exp9;
    int         n;
    repeat (5) @(negedge clk);
    // R1 reset state
    check("R1 txd idle", int'(txd), 1);
    check("R1 irq", int'(irq), 0);
    reg_read(1'b0, v); check("R1 ctrl", int'(v), 8'h00);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(1'b0, v); check("R1 ctrl after release", int'(v), 8'h00);

    // R6 receiver disabled
    send_rx({1'b0, 8'h3C}, 8, 1'b1);
    reg_read(1'b0, v); check("R6 no flag", int'(v[6]), 0);
    reg_read(1'b1, v); check("R6 data kept", int'(v), 8'h00);

    // R7 sweep of all bytes, 8-bit, no filter
    for (int d = 0; d < 256; d++) begin
      reg_write(1'b0, 8'h04);
      send_rx({1'b0, 8'(d)}, 8, 1'b1);
      reg_read(1'b0, v);
      check("R7 flag", int'(v[6]), 1);
      check("R7 stop copy", int'(v[4]), 1);
      reg_read(1'b1, v); check("R7 data", int'(v), d);
      last_rx = 8'(d);
    end
    // R10 sticky flag and irq
    repeat (200) @(negedge clk);
    reg_read(1'b0, v); check("R10 flag holds", int'(v[6]), 1);
    check("R10 irq set", int'(irq), 1);
    reg_write(1'b0, 8'h04);
    #1 check("R10 irq cleared", int'(irq), 0);

    // R8 / R9 filter combinations
    n = 0;
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 2; c++)
        for (int b = 0; b < 2; b++) begin
          v = 8'h41 + 8'(n);
          n++;
          reg_write(1'b0, {3'b000, ~1'(b), 1'b0, 1'b1, 1'(c), 1'(f)});
          if (f == 0) send_rx({1'b0, v}, 8, 1'(b));
          else        send_rx({1'(b), v}, 9, 1'b1);
          exp_f = (c == 0) || (b == 1);
          exp9  = exp_f ? 1'(b) : ~1'(b);
          if (exp_f) last_rx = v;
          reg_read(1'b0, v);
          check(f ? "R9 flag" : "R8 flag", int'(v[6]), int'(exp_f));
          check(f ? "R9 ninth bit" : "R8 stop bit", int'(v[4]), int'(exp9));
          reg_read(1'b1, v);
          check(f ? "R9 data" : "R8 data", int'(v), int'(last_rx));
        end

    // R11 glitch shorter than half a bit
    reg_write(1'b0, 8'h04);
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    reg_read(1'b0, v); check("R11 glitch no flag", int'(v[6]), 0);
    send_rx({1'b0, 8'hC3}, 8, 1'b1);
    reg_read(1'b1, v); check("R11 frame after glitch", int'(v), 8'hC3);

    // R12 control write swept around the flag-set cycle (edge 155 after start drive)
    for (int off = 152; off <= 158; off++) begin
      reg_write(1'b0, 8'h04);
      fork
        send_rx({1'b0, 8'h96}, 8, 1'b1);
        begin
          repeat (off) @(negedge clk);
          reg_sel = 1'b0; reg_wdata = 8'h04; reg_wr = 1'b1;
          @(negedge clk);
          reg_wr = 1'b0;
        end
      join
      reg_read(1'b0, v);
      check("R12 flag vs write", int'(v[6]), int'(off <= 155));
    end

    // R2..R5 transmit sweeps in both formats
    for (int k = 0; k < 16; k++) begin
      send_tx(8'(k * 17 + 3), 1'b0, 1'b0, 1'b0);
      send_tx(8'(k * 29 + 1), 1'b1, 1'(k), 1'b0);
    end
    send_tx(8'hA6, 1'b0, 1'b0, 1'b1);
    send_tx(8'h5B, 1'b1, 1'b1, 1'b1);
    reg_write(1'b0, 8'h00);
    #1 check("R10 irq after clear", int'(irq), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule